// File: doc/BRIEF.md
# Spread-Spectrum Preamble and Header Transmit Framer

This block produces the serial bit stream that opens a direct-sequence spread-spectrum packet. When transmit enable is raised, it sends a run of sync ones whose length comes from a configuration input. A 16-bit start-frame delimiter follows. Last comes a 48-bit header: a signal byte, a service byte, a 16-bit payload airtime in microseconds, and a 16-bit CRC that the block computes on the fly.

A symbol-rate strobe paces the stream. Each strobe produces exactly one bit, which appears on a registered output together with a one-cycle valid flag. The signal byte is taken from one of four per-modulation configuration inputs, picked by a 2-bit modulation select. When the last CRC bit goes out, a done flag rises and stays high, which hands control to the payload path. Dropping transmit enable at any moment clears the framer back to idle.

Top module: `dsss_hdr_framer`

## Requirements
- R1: While `tx_en` is low (and after reset), from the next cycle `tx_bit`, `bit_vld` and `hdr_done` are all 0.
- R2: After `tx_en` rises, the framer needs one setup cycle. From then on, each cycle with `sym_stb` high produces one bit: `bit_vld` is high in the following cycle, with the new `tx_bit`. Without a strobe, `bit_vld` is 0 and `tx_bit` holds.
- R3: The first `sync_len` bits of a frame are all 1.
- R4: The next 16 bits are the delimiter F3A0h sent LSB first: 0,0,0,0,0,1,0,1,1,1,0,0,1,1,1,1.
- R5: The next 8 bits are the signal byte, sent LSB first. It is `sig_m0`, `sig_m1`, `sig_m2` or `sig_m3` for `mod_sel` = 0, 1, 2 or 3.
- R6: After the signal byte come `service` (8 bits), then `length_us` (16 bits), each sent LSB first.
- R7: The last 16 bits are the CRC over the 32 header bits in transmit order. It uses the polynomial x^16+x^12+x^5+1 with the register preset to FFFFh. The remainder is complemented and sent MSB first.
- R8: `hdr_done` rises in the same cycle that the last CRC bit appears, and stays high while `tx_en` is high. Further strobes produce no `bit_vld`.
- R9: Lowering `tx_en` mid-frame aborts the frame. The next enable restarts from the first sync bit.
- R10: With `sync_len` = 0 the frame begins directly with the delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low returns the framer to idle |
| sym_stb | input | 1 | Symbol strobe, one bit per pulse |
| sync_len | input | SYNC_W (8) | Number of sync ones before the delimiter |
| mod_sel | input | 2 | Selects the signal byte source |
| sig_m0 | input | 8 | Signal byte for modulation 0 |
| sig_m1 | input | 8 | Signal byte for modulation 1 |
| sig_m2 | input | 8 | Signal byte for modulation 2 |
| sig_m3 | input | 8 | Signal byte for modulation 3 |
| service | input | 8 | Service field value |
| length_us | input | 16 | Payload airtime in microseconds |
| tx_bit | output | 1 | Serial output bit |
| bit_vld | output | 1 | One-cycle pulse marking a new bit |
| hdr_done | output | 1 | Header complete, held until `tx_en` falls |

## Verification
Every bit is due exactly one cycle after the strobe that requested it, because the state and the output register are updated on the same edge. The bench raises the strobe on a falling edge and samples `tx_bit` and `bit_vld` on the next falling edge. `hdr_done` is due on that same sample after the final CRC strobe. The idle outputs are due one cycle after `tx_en` falls, and they are sampled at the next falling edge. A quiet cycle is inserted between strobes, so holding without a strobe is checked once per bit.

// File: rtl/dsss_hdr_pkg.sv
package dsss_hdr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SYNC, PH_SFD, PH_HDR, PH_CRC, PH_DONE
  } phase_t;

  localparam logic [15:0] SFD_WORD = 16'hF3A0;
  localparam int HDR_BITS = 32;
  localparam int CRC_BITS = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic din);
    logic fb;
    fb = cur[15] ^ din;
    crc_step = {cur[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/hdr_word_mux.sv
module hdr_word_mux (
  input  logic [1:0]  mod_sel,
  input  logic [7:0]  sig_m0,
  input  logic [7:0]  sig_m1,
  input  logic [7:0]  sig_m2,
  input  logic [7:0]  sig_m3,
  input  logic [7:0]  service,
  input  logic [15:0] length_us,
  output logic [31:0] hdr_word
);
  logic [7:0] sig_byte;
  always_comb begin
    case (mod_sel)
      2'd0:    sig_byte = sig_m0;
      2'd1:    sig_byte = sig_m1;
      2'd2:    sig_byte = sig_m2;
      default: sig_byte = sig_m3;
    endcase
  end
  // bit 0 goes out first
  assign hdr_word = {length_us, service, sig_byte};
endmodule

// File: rtl/hdr_crc16.sv
module hdr_crc16
  import dsss_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        step,
  input  logic        din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_PRESET;
    else if (clr)  crc <= CRC_PRESET;
    else if (step) crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/dsss_hdr_framer.sv
module dsss_hdr_framer
  import dsss_hdr_pkg::*;
#(
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              sym_stb,
  input  logic [SYNC_W-1:0] sync_len,
  input  logic [1:0]        mod_sel,
  input  logic [7:0]        sig_m0,
  input  logic [7:0]        sig_m1,
  input  logic [7:0]        sig_m2,
  input  logic [7:0]        sig_m3,
  input  logic [7:0]        service,
  input  logic [15:0]       length_us,
  output logic              tx_bit,
  output logic              bit_vld,
  output logic              hdr_done
);
  localparam int CNT_W = (SYNC_W > 6) ? SYNC_W : 6;

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      hdr_word;
  logic [15:0]      crc;
  logic             cur_bit;
  logic             last;
  phase_t           nxt_ph;

  // named events for the checker
  logic emit;
  logic emit_sync;
  logic crc_step_en;
  assign emit        = sym_stb && (ph != PH_IDLE) && (ph != PH_DONE);
  assign emit_sync   = sym_stb && (ph == PH_SYNC);
  assign crc_step_en = sym_stb && (ph == PH_HDR);

  hdr_word_mux u_mux (
    .mod_sel(mod_sel), .sig_m0(sig_m0), .sig_m1(sig_m1), .sig_m2(sig_m2),
    .sig_m3(sig_m3), .service(service), .length_us(length_us), .hdr_word(hdr_word)
  );

  hdr_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(ph == PH_IDLE), .step(crc_step_en),
    .din(cur_bit), .crc(crc)
  );

  always_comb begin
    cur_bit = 1'b0;
    last    = 1'b0;
    nxt_ph  = ph;
    case (ph)
      PH_SYNC: begin
        cur_bit = 1'b1;
        last    = (cnt == (CNT_W'(sync_len) - CNT_W'(1)));
        nxt_ph  = PH_SFD;
      end
      PH_SFD: begin
        cur_bit = SFD_WORD[cnt[3:0]];
        last    = (cnt == CNT_W'(15));
        nxt_ph  = PH_HDR;
      end
      PH_HDR: begin
        cur_bit = hdr_word[cnt[4:0]];
        last    = (cnt == CNT_W'(HDR_BITS - 1));
        nxt_ph  = PH_CRC;
      end
      PH_CRC: begin
        cur_bit = ~crc[4'd15 - cnt[3:0]];
        last    = (cnt == CNT_W'(CRC_BITS - 1));
        nxt_ph  = PH_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; tx_bit <= 1'b0; bit_vld <= 1'b0; hdr_done <= 1'b0;
    end else if (!tx_en) begin
      ph <= PH_IDLE; cnt <= '0; tx_bit <= 1'b0; bit_vld <= 1'b0; hdr_done <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (ph == PH_IDLE) begin
        ph  <= (sync_len == '0) ? PH_SFD : PH_SYNC;
        cnt <= '0;
      end else if (emit) begin
        tx_bit  <= cur_bit;
        bit_vld <= 1'b1;
        if (last) begin
          ph  <= nxt_ph;
          cnt <= '0;
          if (ph == PH_CRC) hdr_done <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hdr_framer_chk.sv
module hdr_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic sym_stb,
  input logic tx_bit,
  input logic bit_vld,
  input logic hdr_done,
  input logic emit_sync
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!bit_vld && !hdr_done && !tx_bit)); // R1
  AST_VLD_FROM_STB: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(sym_stb)); // R2
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !sym_stb) |=> ($stable(tx_bit) && !bit_vld)); // R2
  AST_SYNC_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_sync && tx_en) |=> tx_bit); // R3
  AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_done) |-> bit_vld); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && tx_en) |=> hdr_done); // R8
  AST_NO_BIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && $past(hdr_done)) |-> !bit_vld); // R8
endmodule

bind dsss_hdr_framer hdr_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sym_stb(sym_stb), .tx_bit(tx_bit),
  .bit_vld(bit_vld), .hdr_done(hdr_done), .emit_sync(emit_sync)
);

// File: tb/sim_dsss_hdr_framer.sv
`timescale 1ns/1ps
module sim_dsss_hdr_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic sym_stb = 1'b0;
  logic [7:0] sync_len = '0;
  logic [1:0] mod_sel = '0;
  logic [7:0] service = '0;
  logic [15:0] length_us = '0;
  logic tx_bit, bit_vld, hdr_done;
  localparam logic [7:0] SG0 = 8'h0A, SG1 = 8'h14, SG2 = 8'h37, SG3 = 8'h6E;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dsss_hdr_framer #(.SYNC_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sym_stb(sym_stb), .sync_len(sync_len),
    .mod_sel(mod_sel), .sig_m0(SG0), .sig_m1(SG1), .sig_m2(SG2), .sig_m3(SG3),
    .service(service), .length_us(length_us), .tx_bit(tx_bit), .bit_vld(bit_vld),
    .hdr_done(hdr_done)
  );

  // stimulus: {sync_len, mod_sel(padded), service, length_us}
  localparam int NV = 5;
  localparam logic [39:0] VEC [NV] = '{
    {8'd128, 8'd0, 8'h00, 16'h0100},
    {8'd8,   8'd1, 8'h00, 16'h0BB8},
    {8'd0,   8'd2, 8'h5A, 16'hFFFF},
    {8'd3,   8'd3, 8'h00, 16'h0001},
    {8'd1,   8'd1, 8'hC3, 16'h8000}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected CRC by augmented long division; preset folded into first 16 bits
  function automatic logic [15:0] exp_crc(input logic [31:0] hw);
    logic [47:0] d;
    d = '0;
    for (int t = 0; t < 32; t++) d[47 - t] = hw[t] ^ (t < 16);
    for (int k = 47; k >= 16; k--)
      if (d[k]) d[k -: 17] = d[k -: 17] ^ 17'h11021;
    return ~d[15:0];
  endfunction

  task automatic run_frame(input logic [7:0] sl, input logic [1:0] ms,
                           input logic [7:0] sv, input logic [15:0] ln);
    logic [511:0] ex;
    logic [7:0] sg;
    logic [31:0] hw;
    logic [15:0] cr;
    int total;
    int e_sync, e_sfd, e_sig, e_fld, e_crc, e_vld, e_hold, e_done;
    e_sync = 0; e_sfd = 0; e_sig = 0; e_fld = 0; e_crc = 0; e_vld = 0; e_hold = 0; e_done = 0;
    sg = (ms == 0) ? SG0 : (ms == 1) ? SG1 : (ms == 2) ? SG2 : SG3;
    hw = {ln, sv, sg};
    cr = exp_crc(hw);
    ex = '0;
    for (int i = 0; i < sl; i++) ex[i] = 1'b1;
    for (int i = 0; i < 16; i++) ex[sl + i] = 16'hF3A0 >> i;
    for (int i = 0; i < 32; i++) ex[sl + 16 + i] = hw[i];
    for (int i = 0; i < 16; i++) ex[sl + 48 + i] = cr[15 - i];
    total = sl + 64;
    sync_len = sl; mod_sel = ms; service = sv; length_us = ln;
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < total; i++) begin
      logic held;
      sym_stb = 1'b1;
      @(negedge clk); sym_stb = 1'b0;
      if (!bit_vld) e_vld++;
      if (tx_bit !== ex[i]) begin
        if (i < sl) e_sync++;
        else if (i < sl + 16) e_sfd++;
        else if (i < sl + 24) e_sig++;
        else if (i < sl + 48) e_fld++;
        else e_crc++;
      end
      if (hdr_done !== (i == total - 1)) e_done++;
      held = tx_bit;
      @(negedge clk);
      if (bit_vld || tx_bit !== held) e_hold++;
    end
    check(e_vld == 0 && e_hold == 0, "R2 strobe pacing", e_vld + e_hold, 0);
    if (sl != 0) check(e_sync == 0, "R3 sync ones", e_sync, 0);
    check(e_sfd == 0, (sl == 0) ? "R10 delimiter first" : "R4 delimiter", e_sfd, 0);
    check(e_sig == 0, "R5 signal byte", e_sig, 0);
    check(e_fld == 0, "R6 service/length", e_fld, 0);
    check(e_crc == 0, "R7 crc", e_crc, 0);
    check(e_done == 0, "R8 done timing", e_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tx_bit && !bit_vld && !hdr_done, "R1 reset state", {tx_bit, bit_vld, hdr_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sym_stb = 1'b1; @(negedge clk); sym_stb = 1'b0; @(negedge clk);
    check(!bit_vld && !tx_bit, "R1 strobe while disabled", {tx_bit, bit_vld}, 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][39:32], VEC[v][25:24], VEC[v][23:16], VEC[v][15:0]);
      // R8: strobes after completion are ignored
      sym_stb = 1'b1; @(negedge clk); sym_stb = 1'b0;
      check(!bit_vld && hdr_done, "R8 after done", {bit_vld, hdr_done}, 1);
      tx_en = 1'b0; @(negedge clk);
      check(!bit_vld && !hdr_done && !tx_bit, "R1 idle after drop",
            {tx_bit, bit_vld, hdr_done}, 0);
    end

    // R9: abort in the header, then restart from sync
    sync_len = 8'd4; mod_sel = 2'd2; service = 8'h11; length_us = 16'h2222;
    tx_en = 1'b1; @(negedge clk); @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      sym_stb = 1'b1; @(negedge clk); sym_stb = 1'b0; @(negedge clk);
    end
    tx_en = 1'b0; @(negedge clk);
    check(!bit_vld && !hdr_done && !tx_bit, "R9 abort clears",
          {tx_bit, bit_vld, hdr_done}, 0);
    run_frame(8'd4, 2'd2, 8'h11, 16'h2222);
    tx_en = 1'b0; @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule